// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host controller program a small bank of configuration registers over a two-wire I2C bus, and lets it poll a live status byte. The bus lines are treated as asynchronous. Each is synchronized and oversampled by a system clock that runs at least sixteen times the bus bit rate. The slave answers on the data line only through an open-drain pull-down enable.

A write transaction runs as follows:

1. Start condition.
2. Chip address with the direction bit clear.
3. Subaddress byte. Its low nibble is the register index and bit 4 turns on auto-increment.
4. Any number of data bytes.
5. Stop condition.

With auto-increment on, successive data bytes fill consecutive registers, and the index wraps from 7 to 0. With it off, every byte lands in the same register. A read transaction returns a status byte. The slave samples that byte again after every master acknowledge, so a master can poll it repeatedly without sending the address again.

The 7-bit chip address is `100010A`. `A` is taken from a strap input: 0 when the strap is open or low, 1 when it is tied high.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, and after any stop condition (SDA rising while SCL is high), the SDA pull-down enable is 0 and the slave waits for a start. All registers reset to 0x00.
- R2: After a start (SDA falling while SCL is high), the slave acknowledges an address byte equal to `{6'b100010, strap_i, rw}`, whatever the value of rw.
- R3: If the address does not match, the slave does not acknowledge the address byte or any later byte, and it writes nothing until the next start.
- R4: In a write transaction, the byte after the address is the subaddress. Its bits 3:0 select the register index, and data bytes are written to that register. Register k appears on `regs_o[8k+7:8k]`.
- R5: When subaddress bit 4 is 1, the index advances by one after each data byte, and index 7 is followed by index 0.
- R6: When subaddress bit 4 is 0, every data byte goes to the same register, so the last byte written remains.
- R7: Data bytes aimed at indices 8 to 15 are acknowledged but leave every register unchanged.
- R8: A read transaction sends the status byte MSB first, one bit per SCL clock. The status byte is `{5'b00000, smute_i, zc_mute_i, pause_n_i}`.
- R9: After each master acknowledge, the slave captures the status inputs again before sending the next byte.
- R10: After a master not-acknowledge, the slave releases SDA until the next start.
- R11: A repeated start, with no stop in between, returns the slave to address reception from any state.
- R12: The slave acknowledges by holding SDA low for the whole high period of the ninth clock, and it changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 1 | Address strap, gives the configurable address bit |
| pause_n_i | input | 1 | Status: pause detected, active low |
| zc_mute_i | input | 1 | Status: zero-crossing mute in effect |
| smute_i | input | 1 | Status: soft mute in effect |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| regs_o | output | 64 | Register file contents, register k at bits 8k+7:8k |

## Verification
The hardest situations to reach from the ports are the ones that depend on state built up across several bytes. The first is index wrap-around under auto-increment. The stimulus reaches it with a subaddress of 6, so that three data bytes cross from 7 to 0. The second is status recapture while a read is in progress. The bench changes the status inputs during the low phase just before each master acknowledge clock, and expects the next byte to carry the new value. A third case keeps clocking bytes after an address mismatch and after a master not-acknowledge, to show the slave stays silent. A final sequence uses a repeated start between two writes, which moves the slave from the data phase back to the address phase without a stop.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
    localparam int DW       = 8;
    localparam int IDXW     = 4;
    localparam int AINC_BIT = 4;
    localparam int CNTW     = 4;
    localparam logic [5:0] ADDR_HI = 6'b100010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_e;

    typedef struct packed {
        bus_state_e       state;
        logic [CNTW-1:0]  cnt;
        logic [DW-1:0]    sh;
        logic [DW-1:0]    tx;
        logic [IDXW-1:0]  idx;
        logic             ainc;
        logic             rw;
        logic             mack;
        logic             oe;
    } fsm_regs_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], line_i};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    parameter int IDXW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] regs_o
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic [DW-1:0] val_q, val_d;
            always_comb begin
                val_d = val_q;
                if (wr_en && (int'(wr_idx) == g)) val_d = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end
            assign regs_o[g*DW +: DW] = val_q;
        end
    endgenerate
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_ev,
    input  logic            stop_ev,
    input  logic            strap_i,
    input  logic [DW-1:0]   status_byte,
    output logic            sda_oe,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [DW-1:0]   wr_data
);
    fsm_regs_t q, d;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (stop_ev) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else if (start_ev) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise && q.cnt < CNTW'(DW)) begin
                        d.sh  = {q.sh[DW-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNTW'(DW)) begin
                        d.cnt = '0;
                        if (q.state == ST_ADDR) begin
                            if (q.sh[DW-1:1] == {ADDR_HI, strap_i}) begin
                                d.rw    = q.sh[0];
                                d.state = ST_ADDR_ACK;
                                d.oe    = 1'b1;
                            end else begin
                                d.state = ST_IGNORE;
                            end
                        end else if (q.state == ST_SUB) begin
                            d.idx   = q.sh[IDXW-1:0];
                            d.ainc  = q.sh[AINC_BIT];
                            d.state = ST_SUB_ACK;
                            d.oe    = 1'b1;
                        end else begin
                            wr_en = (int'(q.idx) < NREG);
                            if (q.ainc)
                                d.idx = (int'(q.idx) == NREG-1) ? '0 : q.idx + 1'b1;
                            d.state = ST_WDATA_ACK;
                            d.oe    = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.state == ST_ADDR_ACK && q.rw) begin
                            d.state = ST_RDATA;
                            d.tx    = status_byte;
                            d.oe    = ~status_byte[DW-1];
                        end else if (q.state == ST_ADDR_ACK) begin
                            d.state = ST_SUB;
                        end else begin
                            d.state = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == CNTW'(DW-1)) begin
                            d.state = ST_RDATA_ACK;
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.mack  = 1'b0;
                        end else begin
                            d.tx  = {q.tx[DW-2:0], 1'b0};
                            d.oe  = ~q.tx[DW-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) d.mack = ~sda_lvl;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.state = ST_RDATA;
                            d.tx    = status_byte;
                            d.oe    = ~status_byte[DW-1];
                        end else begin
                            d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_idx  = q.idx;
    assign wr_data = q.sh;
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               strap_i,
    input  logic               pause_n_i,
    input  logic               zc_mute_i,
    input  logic               smute_i,
    output logic               sda_oe_o,
    output logic [NREG*DW-1:0] regs_o
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_ev, stop_ev;
    logic wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [DW-1:0]   wr_data;
    logic [DW-1:0]   status_byte;

    i2c_line_sync #(.STAGES(2)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(2)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    assign start_ev    = sda_fall & scl_lvl;
    assign stop_ev     = sda_rise & scl_lvl;
    assign status_byte = {5'b00000, smute_i, zc_mute_i, pause_n_i};

    i2c_slave_fsm #(.NREG(NREG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .strap_i(strap_i), .status_byte(status_byte),
        .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    cfg_reg_bank #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(regs_o)
    );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
    parameter int NREG = 8,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_lvl,
    input logic            start_ev,
    input logic            stop_ev,
    input logic            sda_oe,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx
);
    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R11
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);

    // R7
    valid_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG));

    // R4
    write_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_lvl);

    // R12
    drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NREG(NREG), .IDXW(cfg_i2c_pkg::IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module cfg_i2c_slave_bench;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic strap = 1'b0;
    logic [2:0] st = 3'b001;
    logic sda_oe;
    logic [63:0] regs;
    logic sda_bus;

    int compared = 0, mismatched = 0;
    bit busy = 1'b1, done = 1'b0;

    logic [7:0] mreg [8];
    logic [7:0] dq [$];
    int         pend_idx [$];
    logic [7:0] pend_dat [$];

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    cfg_i2c_slave u_cfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .strap_i(strap), .pause_n_i(st[0]), .zc_mute_i(st[1]), .smute_i(st[2]),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int k = 0; k < 8; k++) f[k*8 +: 8] = mreg[k];
        return f;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    // idle-time comparison on every clock (R1, R4)
    always @(negedge clk) begin
        if (rst_n && !busy && !done) begin
            chk("R4 regs", regs, model_flat());
            chk("R1 idle oe", {63'd0, sda_oe}, 64'd0);
        end
    end

    task automatic bus_start();
        busy = 1'b1;
        hw(H); m_sda = 1'b0; hw(H); m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        hw(2); m_sda = 1'b1; hw(H-2); m_scl = 1'b1; hw(H); m_sda = 1'b0; hw(H); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        hw(2); m_sda = 1'b0; hw(H-2); m_scl = 1'b1; hw(H); m_sda = 1'b1; hw(H);
        while (pend_idx.size() > 0) begin
            mreg[pend_idx.pop_front()] = pend_dat.pop_front();
        end
        hw(10);
        busy = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            hw(2); m_sda = b[i]; hw(H-2); m_scl = 1'b1; hw(H); m_scl = 1'b0;
        end
        hw(2); m_sda = 1'b1; hw(H-2); m_scl = 1'b1;
        hw(2); a1 = ~sda_bus; hw(H-4); a2 = ~sda_bus; hw(2);
        m_scl = 1'b0;
        ack = a1 & a2;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack, input logic [2:0] next_st);
        for (int i = 7; i >= 0; i--) begin
            hw(2); m_sda = 1'b1; hw(H-2); m_scl = 1'b1; hw(H/2); b[i] = sda_bus; hw(H/2); m_scl = 1'b0;
        end
        hw(2); st = next_st; m_sda = ~mack; hw(H-2); m_scl = 1'b1; hw(H); m_scl = 1'b0;
    endtask

    // address, subaddress and the bytes in dq; model updates are queued until stop
    task automatic wr_body(input logic [7:0] addr, input logic [7:0] sub, input logic exp_ack, input string tag);
        logic ack;
        int idx;
        send_byte(addr, ack);
        chk({tag, " R2/R3 addr ack"}, {63'd0, ack}, {63'd0, exp_ack});
        send_byte(sub, ack);
        chk({tag, " R12 sub ack"}, {63'd0, ack}, {63'd0, exp_ack});
        idx = int'(sub[3:0]);
        foreach (dq[k]) begin
            send_byte(dq[k], ack);
            chk({tag, " R12 data ack"}, {63'd0, ack}, {63'd0, exp_ack});
            if (exp_ack) begin
                if (idx < 8) begin
                    pend_idx.push_back(idx);
                    pend_dat.push_back(dq[k]);
                end
                if (sub[4]) idx = (idx == 7) ? 0 : (idx + 1) % 16;
            end
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] b;
        for (int k = 0; k < 8; k++) mreg[k] = 8'h00;
        hw(5);
        rst_n = 1'b1;
        hw(3);
        // R1 reset state
        chk("R1 reset regs", regs, 64'd0);
        chk("R1 reset oe", {63'd0, sda_oe}, 64'd0);
        busy = 1'b0;
        hw(20);

        // R5 auto-increment from 2
        bus_start(); dq = {8'hA1, 8'hB2, 8'hC3};
        wr_body(8'h88, 8'h12, 1'b1, "R5 seq"); bus_stop(); hw(20);
        chk("R5 reg4", {56'd0, regs[39:32]}, 64'hC3);

        // R5 wrap 7 -> 0
        bus_start(); dq = {8'h11, 8'h22, 8'h33};
        wr_body(8'h88, 8'h16, 1'b1, "R5 wrap"); bus_stop(); hw(20);
        chk("R5 wrap reg0", {56'd0, regs[7:0]}, 64'h33);

        // R6 fixed index
        bus_start(); dq = {8'h44, 8'h55, 8'h66};
        wr_body(8'h88, 8'h05, 1'b1, "R6"); bus_stop(); hw(20);
        chk("R6 reg5", {56'd0, regs[47:40]}, 64'h66);

        // R7 out-of-range index
        bus_start(); dq = {8'h77, 8'h78};
        wr_body(8'h88, 8'h1A, 1'b1, "R7"); bus_stop(); hw(20);
        chk("R7 unchanged", regs, model_flat());

        // R3 address mismatch (strap 0, address sent with A=1)
        bus_start(); dq = {8'h99, 8'h98};
        wr_body(8'h8A, 8'h11, 1'b0, "R3"); bus_stop(); hw(20);
        chk("R3 unchanged", regs, model_flat());

        // R2 strap moves the address
        strap = 1'b1; hw(20);
        bus_start(); dq = {8'h5A};
        wr_body(8'h8A, 8'h01, 1'b1, "R2 strap"); bus_stop(); hw(20);
        chk("R2 reg1", {56'd0, regs[15:8]}, 64'h5A);
        bus_start(); dq = {8'hEE};
        wr_body(8'h88, 8'h01, 1'b0, "R3 old addr"); bus_stop(); hw(20);

        // R8 / R9 / R10 read with status recapture
        st = 3'b010;
        bus_start();
        send_byte(8'h8B, b[0]);
        chk("R2 read addr ack", {63'd0, b[0]}, 64'd1);
        recv_byte(b, 1'b1, 3'b101);
        chk("R8 status byte", {56'd0, b}, 64'h02);
        recv_byte(b, 1'b1, 3'b111);
        chk("R9 recapture 1", {56'd0, b}, 64'h05);
        recv_byte(b, 1'b0, 3'b000);
        chk("R9 recapture 2", {56'd0, b}, 64'h07);
        recv_byte(b, 1'b0, 3'b000);
        chk("R10 released after nack", {56'd0, b}, 64'hFF);
        bus_stop(); hw(20);

        // R11 repeated start between writes
        bus_start(); dq = {8'h3C, 8'h3D};
        wr_body(8'h8A, 8'h03, 1'b1, "R11 first");
        bus_rstart(); dq = {8'hE1, 8'hE2};
        wr_body(8'h8A, 8'h10, 1'b1, "R11 second");
        bus_stop(); hw(20);
        chk("R11 reg0", {56'd0, regs[7:0]}, 64'hE1);
        chk("R11 reg1", {56'd0, regs[15:8]}, 64'hE2);
        chk("R11 reg3", {56'd0, regs[31:24]}, 64'h3D);

        hw(20);
        summary();
    end
endmodule